// File: doc/BRIEF.md
# Sample-Period Sequencer

This block paces a control engine in fixed sample periods. A clock prescaler and a sample timer, both programmable through a small register write port, produce a period tick. In Control mode each tick opens a compute phase: the busy output rises and stays high until the engine reports completion on `compute_done`. The block then waits, with busy low, for the next tick. In Idle mode no compute phase starts.

A hardware reset, or a software reset command, runs an initialization phase that lasts a fixed, parameterized number of clocks. This phase always ends in Idle mode. The idle output, and the idle flag bit that mirrors it, read 0 until that phase has finished, so a host can wait for its rising edge before touching mode-dependent settings. Mode change commands and the software reset are held as pending and act only at the next sample-period boundary. A command can therefore take up to one full period to take effect.

Host reads go through a combinational read port. It returns a flag word and a status word at fixed addresses. The idle and busy pins are plain status outputs and have no handshake.

Top module: `sps_seq`

## Requirements
- R1: While `rst_n` is low, `busy` and `idle` are 0. After `rst_n` is released, `idle` rises on exactly the INIT_CYCLES-th rising clock edge (default 8) and `busy` stays 0 throughout.
- R2: The sample period is (P+1)*(S+1) clocks. P is the prescaler value written at address 0x0D and S is the timer value written at address 0x0E. Both reset to 3 and 4, which gives 20 clocks.
- R3: In Control mode `busy` rises on the clock edge that ends each period. It falls on the first edge at which `compute_done` is sampled high, provided that edge does not end a period.
- R4: In Idle mode `busy` stays 0 and `compute_done` has no effect.
- R5: A write to address 0x05 posts a command. The value 0x02 selects Control, 0x01 selects Idle and 0x00 requests a software reset. Any other value is ignored. A posted command changes nothing until the next period boundary.
- R6: At the boundary after a software reset request, `idle` and `busy` go to 0 and initialization runs for INIT_CYCLES clocks. The prescaler and timer return to their reset values. The block then enters Idle.
- R7: Reading address 0x00 returns the idle flag in bit 1. Reading address 0x07 returns `busy` in bit 0. All other bits read 0, and any other address reads 0.
- R8: All register writes, commands included, are ignored during initialization.
- R9: If a period ends while `busy` is still high (overrun), a new compute phase starts at once and `busy` stays 1. A `compute_done` sampled on that same edge is ignored.
- R10: A command written on the very edge that ends a period is not applied at that boundary. It takes effect at the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (8) | Register write address |
| wr_data | input | DW (8) | Register write data |
| rd_addr | input | AW (8) | Register read address |
| rd_data | output | DW (8) | Combinational read data |
| compute_done | input | 1 | Engine reports end of compute phase |
| busy | output | 1 | Compute phase in progress |
| idle | output | 1 | Idle mode entered, initialization complete |

## Verification
Two kinds of event can land on the edge that closes a sample period. The first is the engine's `compute_done`. The second is a host command write. The bench counts clocks from an observed busy rise, so it knows the exact boundary edge. It places `compute_done` on that edge and checks that busy stays high on that edge and on the one after it. It also places an Idle command write on a boundary edge and checks that one further compute phase still starts. Idle must then appear only one full period later.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_WAIT = 2'd2,
    ST_BUSY = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_IDLE = 2'd1,
    CMD_CTRL = 2'd2,
    CMD_SRST = 2'd3
  } cmd_e;
endpackage

// File: rtl/sps_regs.sv
module sps_regs
  import sps_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int PW        = 8,
  parameter int TW        = 8,
  parameter int DEF_PRE   = 3,
  parameter int DEF_TMR   = 4,
  parameter logic [AW-1:0] A_FLAG = 8'h00,
  parameter logic [AW-1:0] A_STAT = 8'h07,
  parameter logic [AW-1:0] A_CMD  = 8'h05,
  parameter logic [AW-1:0] A_PRE  = 8'h0D,
  parameter logic [AW-1:0] A_TMR  = 8'h0E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_init,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic          busy,
  input  logic          idle,
  output logic [PW-1:0] pre_val,
  output logic [TW-1:0] tmr_val,
  output cmd_e          pend,
  output logic [DW-1:0] rd_data
);
  logic wr_ok;
  cmd_e new_cmd;

  assign wr_ok = wr_en && !in_init;

  // Decode the command byte; unknown codes map to no command.
  always_comb begin
    new_cmd = CMD_NONE;
    if (wr_ok && wr_addr == A_CMD) begin
      if (wr_data == DW'(0))      new_cmd = CMD_SRST;
      else if (wr_data == DW'(1)) new_cmd = CMD_IDLE;
      else if (wr_data == DW'(2)) new_cmd = CMD_CTRL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_val <= PW'(DEF_PRE);
      tmr_val <= TW'(DEF_TMR);
      pend    <= CMD_NONE;
    end else if (in_init) begin
      pre_val <= PW'(DEF_PRE);
      tmr_val <= TW'(DEF_TMR);
      pend    <= CMD_NONE;
    end else begin
      if (wr_ok && wr_addr == A_PRE) pre_val <= wr_data[PW-1:0];
      if (wr_ok && wr_addr == A_TMR) tmr_val <= wr_data[TW-1:0];
      if (new_cmd != CMD_NONE) pend <= new_cmd;
      else if (tick)           pend <= CMD_NONE;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_FLAG)      rd_data[1] = idle;
    else if (rd_addr == A_STAT) rd_data[0] = busy;
  end
endmodule

// File: rtl/sps_timer.sv
module sps_timer #(
  parameter int PW = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic [PW-1:0] pre_val,
  input  logic [TW-1:0] tmr_val,
  output logic          tick
);
  logic [PW-1:0] pre_cnt;
  logic [TW-1:0] tmr_cnt;
  logic          pre_hit;
  logic          tmr_hit;

  // Compare with >= so a value lowered mid-count never forces a wrap.
  assign pre_hit = pre_cnt >= pre_val;
  assign tmr_hit = tmr_cnt >= tmr_val;
  assign tick    = pre_hit && tmr_hit && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      tmr_cnt <= '0;
    end else if (hold) begin
      pre_cnt <= '0;
      tmr_cnt <= '0;
    end else if (pre_hit) begin
      pre_cnt <= '0;
      tmr_cnt <= tmr_hit ? '0 : tmr_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sps_fsm.sv
module sps_fsm
  import sps_pkg::*;
#(
  parameter int INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic compute_done,
  input  cmd_e pend,
  output logic busy,
  output logic idle,
  output logic in_init
);
  localparam int ICW = $clog2(INIT_CYCLES + 1);

  seq_state_e        state, nxt;
  logic [ICW-1:0]    init_cnt;

  always_comb begin
    nxt = state;
    if (state == ST_INIT) begin
      if (init_cnt == ICW'(INIT_CYCLES - 1)) nxt = ST_IDLE;
    end else if (tick) begin
      unique case (pend)
        CMD_SRST: nxt = ST_INIT;
        CMD_IDLE: nxt = ST_IDLE;
        CMD_CTRL: nxt = ST_BUSY;
        default:  nxt = (state == ST_IDLE) ? ST_IDLE : ST_BUSY;
      endcase
    end else if (state == ST_BUSY && compute_done) begin
      nxt = ST_WAIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_INIT;
      init_cnt <= '0;
    end else begin
      state    <= nxt;
      init_cnt <= (state == ST_INIT) ? init_cnt + 1'b1 : '0;
    end
  end

  assign busy    = (state == ST_BUSY);
  assign idle    = (state == ST_IDLE);
  assign in_init = (state == ST_INIT);
endmodule

// File: rtl/sps_seq.sv
module sps_seq
  import sps_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int PW          = 8,
  parameter int TW          = 8,
  parameter int DEF_PRE     = 3,
  parameter int DEF_TMR     = 4,
  parameter int INIT_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          compute_done,
  output logic          busy,
  output logic          idle
);
  logic          period_tick;
  logic          in_init;
  logic [PW-1:0] pre_val;
  logic [TW-1:0] tmr_val;
  cmd_e          pend;

  sps_regs #(
    .AW(AW), .DW(DW), .PW(PW), .TW(TW),
    .DEF_PRE(DEF_PRE), .DEF_TMR(DEF_TMR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .in_init(in_init), .tick(period_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .busy(busy), .idle(idle),
    .pre_val(pre_val), .tmr_val(tmr_val), .pend(pend), .rd_data(rd_data)
  );

  sps_timer #(.PW(PW), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold(in_init),
    .pre_val(pre_val), .tmr_val(tmr_val), .tick(period_tick)
  );

  sps_fsm #(.INIT_CYCLES(INIT_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(period_tick),
    .compute_done(compute_done), .pend(pend),
    .busy(busy), .idle(idle), .in_init(in_init)
  );
endmodule

// File: rtl/sps_seq_chk.sv
module sps_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic idle,
  input logic compute_done,
  input logic tick
);
  // R4
  busy_idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && idle));

  // R3
  busy_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick));

  // R9
  busy_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(compute_done) || $past(tick)));

  // R5
  idle_leave_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(tick));
endmodule

bind sps_seq sps_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .idle(idle),
  .compute_done(compute_done), .tick(period_tick)
);

// File: tb/sps_seq_bench.sv
module sps_seq_bench;
  localparam int P_DEF = 20;
  localparam int NV = 6;
  localparam int VPRE [NV] = '{1, 0, 4, 2, 7, 3};
  localparam int VTMR [NV] = '{1, 5, 0, 3, 2, 4};
  localparam int VEXP [NV] = '{4, 6, 5, 12, 24, 20};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       compute_done = 1'b0;
  logic       busy, idle;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sps_seq u_sps_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .compute_done(compute_done), .busy(busy), .idle(idle)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    compute_done = 1'b1;
    step();
    compute_done = 1'b0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (!busy && n < 400) begin step(); n++; end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!idle && n < 400) begin step(); n++; end
  endtask

  // Period between two busy rises, with the phase closed after one clock.
  task automatic measure(string req, int exp);
    int n;
    wait_busy(n);
    done_pulse();
    chk("R3 busy low after done", busy, 0);
    n = 1;
    while (!busy && n < 400) begin step(); n++; end
    chk(req, n, exp);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    // Reset state and initialization length (R1, R7)
    step(); step();
    chk("R1 busy in reset", busy, 0);
    chk("R1 idle in reset", idle, 0);
    rst_n = 1'b1;
    wait_idle(n);
    chk("R1 init length", n, 8);
    rd_addr = 8'h00; #1;
    chk("R7 flag word", rd_data, 2);
    rd_addr = 8'h07; #1;
    chk("R7 status idle", rd_data, 0);

    // R4: compute_done in Idle
    for (int k = 0; k < 50; k++) begin
      compute_done = (k % 3 == 0);
      step();
      if (busy) chk("R4 busy in idle", busy, 0);
    end
    compute_done = 1'b0;
    chk("R4 still idle", idle, 1);

    // R5: unknown command code ignored
    wr(8'h05, 8'h37);
    for (int k = 0; k < 50; k++) step();
    chk("R5 bad code ignored", idle, 1);
    chk("R5 no busy", busy, 0);

    // R2 table
    for (int i = 0; i < NV; i++) begin
      wr(8'h0D, 8'(VPRE[i]));
      wr(8'h0E, 8'(VTMR[i]));
      wr(8'h05, 8'h02);
      measure("R2 period", VEXP[i]);
      done_pulse();
      wr(8'h05, 8'h01);
      chk("R5 idle not yet", idle, 0);
      wait_idle(n);
      chk("R5 idle reached", idle, 1);
      chk("R5 within a period", int'(n <= VEXP[i]), 1);
    end

    // Control, default period: R7 while busy, R9 overrun, R10
    wr(8'h05, 8'h02);
    wait_busy(n);
    rd_addr = 8'h07; #1;
    chk("R7 status busy", rd_data, 1);
    rd_addr = 8'h00; #1;
    chk("R7 flag in control", rd_data, 0);
    rd_addr = 8'h03; #1;
    chk("R7 other addr", rd_data, 0);
    for (int k = 0; k < P_DEF - 1; k++) step();
    chk("R9 busy held", busy, 1);
    done_pulse();
    chk("R9 overrun keeps busy", busy, 1);
    step();
    chk("R9 done at boundary ignored", busy, 1);
    done_pulse();
    chk("R3 busy falls", busy, 0);
    for (int k = 0; k < P_DEF - 3; k++) step();
    wr(8'h05, 8'h01);
    chk("R10 busy at boundary", busy, 1);
    chk("R10 not idle yet", idle, 0);
    done_pulse();
    for (int k = 0; k < P_DEF - 2; k++) step();
    chk("R10 idle late", idle, 0);
    step();
    chk("R10 idle after next boundary", idle, 1);

    // R6 / R8: soft reset with writes during init
    wr(8'h0D, 8'h01);
    wr(8'h05, 8'h00);
    n = 0;
    while (idle && n < 400) begin step(); n++; end
    chk("R6 reset at boundary", int'(n <= P_DEF), 1);
    chk("R6 busy in init", busy, 0);
    wr(8'h0D, 8'h00);
    wr(8'h05, 8'h02);
    n = 2;
    while (!idle && n < 400) begin step(); n++; end
    chk("R6 init length", n, 8);
    for (int k = 0; k < 3 * P_DEF; k++) step();
    chk("R8 command in init ignored", idle, 1);
    wr(8'h05, 8'h02);
    measure("R6 R8 default period", P_DEF);

    // R1: hardware reset mid-phase
    rst_n = 1'b0; #1;
    chk("R1 busy on reset", busy, 0);
    chk("R1 idle on reset", idle, 0);
    step();
    rst_n = 1'b1;
    wait_idle(n);
    chk("R1 init after reset", n, 8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule